// File: doc/BRIEF.md
# DTMF Dual-Tone Sine Generator

This block produces a dual-tone multi-frequency signal as a stream of signed digital samples, one sample per clock of a 3.579545 MHz clock. A 4-bit key code chooses one frequency from a low group and one from a high group. Each group has its own 24-bit phase accumulator. The top bits of each accumulator address a quarter-wave sine table. The two sine values are scaled so that the high-group tone is about 2 dB louder than the low-group tone, and the two are added into one 12-bit two's-complement word. A DAC and filter outside the block turn this word into the line signal.

A host writes the key code through a write-only register and starts or stops the tone through an enable bit. The key is captured only when the enable turns on, so rewriting the code during a burst has no effect on the tone. While the tone is off, the output rests at zero, which is the mid-scale level and stands for signal ground. A power-down input clears both the code and the enable. A synchronous active-high reset does the same.

Top module: `dtmf_tone_gen`

## Requirements
- R1: The key code maps to a tone pair. Low group: 697 Hz for codes 0001, 0010, 0011 and 1101; 770 Hz for 0100, 0101, 0110 and 1110; 852 Hz for 0111, 1000, 1001 and 1111; 941 Hz for 1010, 1011, 1100 and 0000. High group: 1209 Hz for 0001, 0100, 0111 and 1011; 1336 Hz for 0010, 0101, 1000 and 1010; 1477 Hz for 0011, 0110, 1001 and 1100; 1633 Hz for 1101, 1110, 1111 and 0000.
- R2: Each generated frequency is within ±1.5 % of its nominal value. The phase step is round(f·2^24/3579545), and each clock produces one new sample.
- R3: The code register is copied into the tone selection only on the clock edge where the enable goes from 0 to 1. A code write while the enable is 1 leaves both frequencies unchanged.
- R4: When the enable is 0, `sample_o` is 0 (mid-scale). The clock edge after the edge that clears the enable is the first edge to show 0. Code writes made while the tone is off keep the output at 0.
- R5: On the edge where the enable rises, both accumulators restart at zero phase. The first tone sample appears one edge later and is within 12 LSB of 0.
- R6: The high-group amplitude is about 1139 LSB and the low-group amplitude is about 900 LSB, a ratio of about 0.79 (about 2 dB). The output equals the sum of the two sines within 12 LSB.
- R7: `pwr_down` = 1 at a clock edge clears the code register to 0000 and the enable to 0. The output is 0 one edge later. A later enable with no code write produces the 0000 pair (941 Hz and 1633 Hz).
- R8: After reset, `sample_o` is 0 and the code register holds 0000.
- R9: A write of enable = 1 while the tone is already on does not restart the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, nominal 3.579545 MHz |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Clears the code register and the enable |
| code_wr | input | 1 | Write strobe for the key code register |
| code_din | input | 4 | Key code to write |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_din | input | 1 | Enable value to write |
| sample_o | output | 12 | Two's-complement dual-tone sample; 0 when idle |

## Verification
All sixteen key codes are played for 600 samples each. Every sample is compared with a floating-point sum of two ideal sines at the nominal frequencies. Over that length, a neighbouring row or column frequency drifts by far more than the tolerance, so a swapped or misdecoded code stands out. The same comparison also catches a wrong group weight and a bad quadrant fold. Further bursts write a new code, or a repeated enable, partway through the tone and expect the original waveform to continue unbroken; this separates latch-at-start from follow-the-register behaviour and catches a phase restart. A power-down in the middle of a tone, followed by an enable with no code write, shows that the register was cleared to the 941/1633 Hz code.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int unsigned CLK_HZ      = 3579545;
    localparam int          PHASE_W     = 24;
    localparam int          ROM_AW      = 8;
    localparam int          ROM_DEPTH   = 1 << ROM_AW;
    localparam int          OUT_W       = 12;
    localparam int          MAG_W       = OUT_W - 1;
    localparam int          MAG_MAX     = (1 << MAG_W) - 1;
    localparam int          TONES_GRP   = 4;
    localparam int          STEP_N      = 2 * TONES_GRP;
    localparam int          LO_WEIGHT   = 450;
    localparam int          HI_WEIGHT   = 570;
    localparam int          WEIGHT_SH   = 10;
    localparam int          WGT_W       = WEIGHT_SH + 1;
    localparam int          PROD_W      = OUT_W + WGT_W;
    localparam real         HALF_PI     = 1.5707963267948966;

    typedef struct packed {
        logic [1:0] row;
        logic [1:0] col;
    } key_t;

    typedef logic [ROM_DEPTH-1:0][MAG_W-1:0] rom_t;
    typedef logic [STEP_N-1:0][PHASE_W-1:0]  step_tab_t;

    function automatic key_t decode_key(input logic [3:0] c);
        key_t k;
        unique case (c)
            4'h1: k = '{2'd0, 2'd0};
            4'h2: k = '{2'd0, 2'd1};
            4'h3: k = '{2'd0, 2'd2};
            4'h4: k = '{2'd1, 2'd0};
            4'h5: k = '{2'd1, 2'd1};
            4'h6: k = '{2'd1, 2'd2};
            4'h7: k = '{2'd2, 2'd0};
            4'h8: k = '{2'd2, 2'd1};
            4'h9: k = '{2'd2, 2'd2};
            4'hA: k = '{2'd3, 2'd1};
            4'hB: k = '{2'd3, 2'd0};
            4'hC: k = '{2'd3, 2'd2};
            4'hD: k = '{2'd0, 2'd3};
            4'hE: k = '{2'd1, 2'd3};
            4'hF: k = '{2'd2, 2'd3};
            default: k = '{2'd3, 2'd3};
        endcase
        return k;
    endfunction

    // Entries 0..3 are the low group, 4..7 the high group.
    function automatic int unsigned tone_hz(input int k);
        case (k)
            0: return 697;
            1: return 770;
            2: return 852;
            3: return 941;
            4: return 1209;
            5: return 1336;
            6: return 1477;
            default: return 1633;
        endcase
    endfunction

    function automatic step_tab_t build_steps();
        step_tab_t t;
        longint unsigned num;
        for (int k = 0; k < STEP_N; k++) begin
            num  = (longint'(tone_hz(k)) << PHASE_W) + longint'(CLK_HZ / 2);
            t[k] = PHASE_W'(num / longint'(CLK_HZ));
        end
        return t;
    endfunction

    // Quarter-wave table sampled at the middle of each slot.
    function automatic rom_t build_rom();
        rom_t r;
        real x, x2, s;
        for (int i = 0; i < ROM_DEPTH; i++) begin
            x  = (real'(i) + 0.5) * HALF_PI / real'(ROM_DEPTH);
            x2 = x * x;
            s  = x * (1.0 - x2 / 6.0 * (1.0 - x2 / 20.0 * (1.0 - x2 / 42.0 *
                 (1.0 - x2 / 72.0 * (1.0 - x2 / 110.0)))));
            r[i] = MAG_W'($rtoi(s * real'(MAG_MAX) + 0.5));
        end
        return r;
    endfunction

    localparam step_tab_t STEP_TAB = build_steps();
    localparam rom_t      SINE_ROM = build_rom();

endpackage

// File: rtl/dtmf_ctrl.sv
module dtmf_ctrl
    import dtmf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_down,
    input  logic       code_wr,
    input  logic [3:0] code_din,
    input  logic       en_wr,
    input  logic       en_din,
    output logic       active,
    output logic       start,
    output key_t       key
);
    logic [3:0] code_q;
    logic       active_q;
    key_t       key_q;

    assign start  = en_wr & en_din & ~active_q & ~pwr_down;
    assign active = active_q;
    assign key    = key_q;

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            code_q   <= '0;
            active_q <= 1'b0;
            key_q    <= '0;
        end else begin
            if (code_wr) code_q   <= code_din;
            if (en_wr)   active_q <= en_din;
            if (start)   key_q    <= decode_key(code_q);
        end
    end

    // R3
    key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q)) |-> (key_q == $past(key_q)));

    // R7
    pd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_down) |-> (!active_q && code_q == 4'h0));

endmodule

// File: rtl/dtmf_nco.sv
module dtmf_nco
    import dtmf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               run,
    input  logic [PHASE_W-1:0] step,
    output logic [ROM_AW+1:0]  phase_top
);
    logic [PHASE_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst || start)
            acc <= '0;
        else if (run)
            acc <= acc + step;
    end

    assign phase_top = acc[PHASE_W-1 -: ROM_AW+2];

    // R5
    phase_zero_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase_top == '0));

endmodule

// File: rtl/dtmf_sine.sv
module dtmf_sine
    import dtmf_pkg::*;
(
    input  logic [ROM_AW+1:0]        ph,
    output logic signed [OUT_W-1:0]  wave
);
    logic [1:0]        quad;
    logic [ROM_AW-1:0] idx;
    logic [ROM_AW-1:0] addr;
    logic [MAG_W-1:0]  mag;

    always_comb begin
        quad = ph[ROM_AW+1:ROM_AW];
        idx  = ph[ROM_AW-1:0];
        addr = quad[0] ? ~idx : idx;
        mag  = SINE_ROM[addr];
        wave = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
    import dtmf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_down,
    input  logic             code_wr,
    input  logic [3:0]       code_din,
    input  logic             en_wr,
    input  logic             en_din,
    output logic [OUT_W-1:0] sample_o
);
    logic active;
    logic start;
    key_t key;
    logic [1:0][OUT_W-1:0] terms;
    logic signed [OUT_W:0] sum;

    dtmf_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .code_wr  (code_wr),
        .code_din (code_din),
        .en_wr    (en_wr),
        .en_din   (en_din),
        .active   (active),
        .start    (start),
        .key      (key)
    );

    // Group 0 is the low (row) tone, group 1 the high (column) tone.
    for (genvar g = 0; g < 2; g++) begin : grp
        localparam logic GBIT   = 1'(g);
        localparam int   WEIGHT = (g == 0) ? LO_WEIGHT : HI_WEIGHT;
        logic [1:0]               sel;
        logic [2:0]               tix;
        logic [PHASE_W-1:0]       step;
        logic [ROM_AW+1:0]        ph;
        logic signed [OUT_W-1:0]  wave;
        logic signed [PROD_W-1:0] prod;

        if (g == 0) begin : g_row
            assign sel = key.row;
        end else begin : g_col
            assign sel = key.col;
        end

        assign tix  = {GBIT, sel};
        assign step = STEP_TAB[tix];

        dtmf_nco u_nco (
            .clk       (clk),
            .rst       (rst),
            .start     (start),
            .run       (active),
            .step      (step),
            .phase_top (ph)
        );

        dtmf_sine u_sine (
            .ph   (ph),
            .wave (wave)
        );

        assign prod     = PROD_W'(wave) * PROD_W'(WEIGHT);
        assign terms[g] = OUT_W'(prod >>> WEIGHT_SH);
    end

    assign sum = (OUT_W+1)'($signed(terms[0])) + (OUT_W+1)'($signed(terms[1]));

    always_ff @(posedge clk) begin
        if (rst)
            sample_o <= '0;
        else
            sample_o <= active ? OUT_W'(sum) : '0;
    end

    // R4
    idle_mid_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> (sample_o == '0));

endmodule

// File: tb/sim_dtmf_tone_gen.sv
module sim_dtmf_tone_gen;

    localparam real FCLK   = 3579545.0;
    localparam real TWO_PI = 6.283185307179586;
    localparam real AMP_HI = 2047.0 * 570.0 / 1024.0;
    localparam real AMP_LO = 2047.0 * 450.0 / 1024.0;
    localparam int  TOL    = 12;
    localparam int  NSAMP  = 600;

    typedef struct packed {
        logic [3:0]  code;
        logic [10:0] lo;
        logic [10:0] hi;
    } vec_t;

    // R1: code -> (low Hz, high Hz)
    localparam vec_t VECS [16] = '{
        '{4'h1, 11'd697, 11'd1209}, '{4'h2, 11'd697, 11'd1336},
        '{4'h3, 11'd697, 11'd1477}, '{4'h4, 11'd770, 11'd1209},
        '{4'h5, 11'd770, 11'd1336}, '{4'h6, 11'd770, 11'd1477},
        '{4'h7, 11'd852, 11'd1209}, '{4'h8, 11'd852, 11'd1336},
        '{4'h9, 11'd852, 11'd1477}, '{4'hA, 11'd941, 11'd1336},
        '{4'hB, 11'd941, 11'd1209}, '{4'hC, 11'd941, 11'd1477},
        '{4'hD, 11'd697, 11'd1633}, '{4'hE, 11'd770, 11'd1633},
        '{4'hF, 11'd852, 11'd1633}, '{4'h0, 11'd941, 11'd1633}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_down = 1'b0;
    logic        code_wr = 1'b0;
    logic [3:0]  code_din = 4'h0;
    logic        en_wr = 1'b0;
    logic        en_din = 1'b0;
    logic [11:0] sample_o;

    int checks = 0;
    int fails  = 0;
    int first_sample = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dtmf_tone_gen u0 (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .code_wr  (code_wr),
        .code_din (code_din),
        .en_wr    (en_wr),
        .en_din   (en_din),
        .sample_o (sample_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_code(input logic [3:0] c);
        code_wr = 1'b1; code_din = c;
        tick();
        code_wr = 1'b0;
    endtask

    // Starts the tone, compares n samples with the ideal sum of sines.
    // At sample mid_at a new code mid_code is written; at reen_at enable=1 is rewritten.
    task automatic burst(input int lo, input int hi, input int n,
                         input int mid_at, input logic [3:0] mid_code,
                         input int reen_at, input string req);
        int maxerr = 0;
        en_wr = 1'b1; en_din = 1'b1;
        tick();
        en_wr = 1'b0;
        for (int i = 0; i < n; i++) begin
            real t, e;
            int got, err;
            tick();
            t   = real'(i) / FCLK;
            e   = AMP_LO * $sin(TWO_PI * real'(lo) * t) + AMP_HI * $sin(TWO_PI * real'(hi) * t);
            got = int'($signed(sample_o));
            if (i == 0) first_sample = got;
            err = $rtoi(e - real'(got) + ((e - real'(got)) >= 0.0 ? 0.5 : -0.5));
            if (err < 0) err = -err;
            if (err > maxerr) maxerr = err;
            code_wr = (i == mid_at);
            code_din = mid_code;
            en_wr  = (i == reen_at);
            en_din = 1'b1;
        end
        code_wr = 1'b0;
        en_wr   = 1'b0;
        chk(maxerr <= TOL, req, maxerr, TOL);
    endtask

    task automatic stop_tone(input string req);
        en_wr = 1'b1; en_din = 1'b0;
        tick();
        en_wr = 1'b0;
        tick();
        chk(sample_o == 12'h000, req, int'($signed(sample_o)), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(sample_o == 12'h000, "R8 reset output", int'($signed(sample_o)), 0);

        // R1 R2 R6: every code against its nominal tone pair; R4 after each burst
        for (int v = 0; v < 16; v++) begin
            write_code(VECS[v].code);
            burst(int'(VECS[v].lo), int'(VECS[v].hi), NSAMP, -1, 4'h0, -1, "R1 R2 R6 tone pair");
            if (v == 0)
                chk(first_sample <= TOL && first_sample >= -TOL, "R5 zero phase start", first_sample, 0);
            stop_tone("R4 idle after disable");
        end

        // R8: register held 0000 after reset -> re-checked by reset then enabling
        rst = 1'b1; tick(); rst = 1'b0; tick();
        burst(941, 1633, 200, -1, 4'h0, -1, "R8 code cleared by reset");
        stop_tone("R4 idle after disable");

        // R3: code rewrite mid-burst must not change the tone
        write_code(4'h5);
        burst(770, 1336, NSAMP, 200, 4'hC, -1, "R3 code write during tone ignored");
        stop_tone("R4 idle after disable");

        // R3: the code written during the last burst is used by the next start
        burst(941, 1477, 300, -1, 4'h0, -1, "R3 new code taken at next start");
        stop_tone("R4 idle after disable");

        // R9: re-writing enable=1 while on keeps phase running
        write_code(4'h9);
        burst(852, 1477, NSAMP, -1, 4'h0, 300, "R9 repeated enable keeps phase");
        stop_tone("R4 idle after disable");

        // R4: code writes while idle leave output at mid-scale
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) begin
                code_wr = 1'b1; code_din = 4'(i);
                tick();
                if (sample_o != 12'h000) bad++;
            end
            code_wr = 1'b0;
            chk(bad == 0, "R4 idle with code writes", bad, 0);
        end

        // R7: power-down mid tone
        write_code(4'h3);
        burst(697, 1477, 50, -1, 4'h0, -1, "R2 short burst");
        pwr_down = 1'b1;
        tick();
        pwr_down = 1'b0;
        tick();
        chk(sample_o == 12'h000, "R7 power-down silences", int'($signed(sample_o)), 0);
        repeat (3) tick();
        chk(sample_o == 12'h000, "R7 stays off after power-down", int'($signed(sample_o)), 0);
        burst(941, 1633, NSAMP, -1, 4'h0, -1, "R7 code cleared to 0000");
        chk(first_sample <= TOL && first_sample >= -TOL, "R5 zero phase restart", first_sample, 0);
        stop_tone("R4 idle after disable");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule